// File: doc/BRIEF.md
# Sized Load/Store Byte-Lane Unit

This unit connects a processor's load/store stage to a 32-bit RAM that has a write enable for each byte. A request carries a byte address, an access size (byte, halfword or word), a store flag, store data and a flag that selects sign or zero extension for loads. On a store, the unit decodes the size and the two low address bits into byte-lane write strobes. It copies the store data onto every lane, so the enabled lanes always hold the right bytes. The RAM updates only the enabled bytes, so a partial store needs no read-modify-write.

On a load, the RAM returns the whole word one cycle later. The unit keeps the size, the byte offset and the extension flag in registers until then. It uses them to shift the addressed byte or halfword down to bit 0 and to extend it to 32 bits. A request that is not naturally aligned, or that uses the reserved size code, is rejected. The unit raises an error pulse, enables no lanes and returns no load data for it. The byte-enable RAM model is part of the block.

Top module: `lsu_lane_unit`

## Requirements
- R1: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved. A halfword with address bit 0 set, a word with either of address bits 1:0 set, and any request with the reserved code are misaligned. Every byte access is aligned.
- R2: An aligned word store drives `mem_be` to 4'b1111.
- R3: An aligned halfword store drives `mem_be` to 4'b0011 when address bit 1 is 0, and to 4'b1100 when it is 1.
- R4: A byte store drives `mem_be` to a single set bit at position addr[1:0], where lane n holds data bits 8n+7:8n.
- R5: `mem_wdata` carries the store byte copied into all four lanes for a byte store, and the store halfword copied into both halves for a halfword store. It carries the store word unchanged for a word store.
- R6: A misaligned request of either kind drives `mem_be` to 0 in its own cycle. It raises `err` for exactly the following cycle, with `load_valid` low, and it leaves memory unchanged.
- R7: A load with `req_signed` = 0 returns the addressed byte or halfword in the low bits of `load_data` with the upper bits zero. A word load returns the whole word.
- R8: A load with `req_signed` = 1 fills the upper bits of `load_data` with the top bit of the addressed byte or halfword.
- R9: `load_valid` and `load_data` are presented in the cycle after an aligned load request. `load_data` is 0 whenever `load_valid` is low.
- R10: A partial store leaves the bytes of the word outside the enabled lanes unchanged.
- R11: After reset, `err` and `load_valid` are low and `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Store data, right-justified |
| req_signed | input | 1 | Sign-extend load data when 1 |
| mem_be | output | 4 | Byte-lane write strobes sent to the RAM |
| mem_wdata | output | 32 | Lane-replicated store data |
| err | output | 1 | Misaligned-request pulse, one cycle after the request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with ADDR_W = 8, which gives a 64-word RAM. At that size the bench can first fill every word with a known pattern and then hit the same words many times with random mixed-size stores and loads. Partial writes, sign boundaries such as 0x80 and 0x8000, and misaligned requests therefore land on bytes whose expected value the model already holds. Every offset and size combination, including the reserved code, comes up within a few thousand cycles.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Natural-alignment check; the reserved code is always rejected.
  function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: is_misaligned = 1'b0;
      SZ_HALF: is_misaligned = off[0];
      SZ_WORD: is_misaligned = |off;
      default: is_misaligned = 1'b1;
    endcase
  endfunction

  // Byte-lane strobes for an aligned access.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = off[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  endfunction

  // Copy right-justified store data onto every lane it could occupy.
  function automatic logic [DATA_W-1:0] replicate(input logic [1:0] sz, input logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: replicate = {4{d[7:0]}};
      SZ_HALF: replicate = {2{d[15:0]}};
      default: replicate = d;
    endcase
  endfunction

  // Pull the addressed part out of a RAM word and extend it.
  function automatic logic [DATA_W-1:0] extract(input logic [1:0] sz, input logic [1:0] off,
                                                input logic sext, input logic [DATA_W-1:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*off +: 8];
    h = off[1] ? w[31:16] : w[15:0];
    case (sz)
      SZ_BYTE: extract = {{24{sext & b[7]}}, b};
      SZ_HALF: extract = {{16{sext & h[15]}}, h};
      default: extract = w;
    endcase
  endfunction
endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_pkg::*;
(
  input  logic              valid,
  input  logic              store,
  input  logic [1:0]        offset,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_out,
  output logic              bad,
  output logic              wr_en,
  output logic              rd_en
);
  logic mis;
  logic [LANES-1:0] mask;

  assign mis   = is_misaligned(size, offset);
  assign mask  = lane_mask(size, offset);
  assign bad   = valid & mis;
  assign wr_en = valid & store & ~mis;
  assign rd_en = valid & ~store & ~mis;

  // One gate per lane: strobe only on an accepted store.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = wr_en & mask[i];
  end

  assign wdata_out = replicate(size, wdata_in);
endmodule

// File: rtl/lsu_byte_ram.sv
module lsu_byte_ram
  import lsu_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we && be[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
    end
    if (re) rdata <= mem[idx];
  end

  AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (be != '0)); // R10
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              bad_in,
  input  logic [1:0]        size,
  input  logic [1:0]        offset,
  input  logic              sext,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data,
  output logic              err
);
  logic       lv_q, err_q, sext_q;
  logic [1:0] size_q, off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q   <= 1'b0;
      err_q  <= 1'b0;
      sext_q <= 1'b0;
      size_q <= SZ_BYTE;
      off_q  <= 2'b00;
    end else begin
      lv_q  <= rd_en;
      err_q <= bad_in;
      if (rd_en) begin
        sext_q <= sext;
        size_q <= size;
        off_q  <= offset;
      end
    end
  end

  assign load_valid = lv_q;
  assign err        = err_q;
  assign load_data  = lv_q ? extract(size_q, off_q, sext_q, ram_rdata) : '0;

  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !sext_q && size_q == SZ_BYTE) |-> (load_data[31:8] == '0)); // R7
  AST_SEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && sext_q && size_q == SZ_HALF) |-> (load_data[31:16] == {16{load_data[15]}})); // R8
  AST_ERR_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !load_valid); // R6
  AST_ERR_FOLLOWS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_in |=> err); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (load_data == '0)); // R9
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORDS = 1 << (ADDR_W - 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic [31:0]       req_wdata,
  input  logic              req_signed,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic              err,
  output logic              load_valid,
  output logic [31:0]       load_data
);
  logic              dec_bad, dec_wr, dec_rd;
  logic [DATA_W-1:0] ram_rdata;

  lsu_req_decode u_dec (
    .valid(req_valid), .store(req_store), .offset(req_addr[1:0]), .size(req_size),
    .wdata_in(req_wdata), .be(mem_be), .wdata_out(mem_wdata),
    .bad(dec_bad), .wr_en(dec_wr), .rd_en(dec_rd)
  );

  lsu_byte_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(dec_wr), .re(dec_rd),
    .idx(req_addr[ADDR_W-1:2]), .be(mem_be), .wdata(mem_wdata), .rdata(ram_rdata)
  );

  lsu_load_align u_align (
    .clk(clk), .rst_n(rst_n), .rd_en(dec_rd), .bad_in(dec_bad),
    .size(req_size), .offset(req_addr[1:0]), .sext(req_signed), .ram_rdata(ram_rdata),
    .load_valid(load_valid), .load_data(load_data), .err(err)
  );

  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == SZ_WORD && req_addr[1:0] == 2'b00) |-> (mem_be == 4'hF)); // R2
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == SZ_HALF && !req_addr[0]) |-> (mem_be == 4'b0011 || mem_be == 4'b1100)); // R3
  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == SZ_BYTE) |-> ($countones(mem_be) == 1)); // R4
  AST_BAD_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |-> (mem_be == 4'b0000)); // R6
  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_RSVD) |=> err); // R1
endmodule

// File: tb/lsu_lane_unit_bench.sv
module lsu_lane_unit_bench;
  localparam int AW = 8;
  localparam int NBYTES = 1 << AW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 0;
  logic          req_store = 0;
  logic [31:0]   req_wdata = 0;
  logic          req_signed = 0;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, load_data;
  logic          err, load_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [NBYTES];

  always #10 clk = ~clk;

  lsu_lane_unit #(.ADDR_W(AW)) u_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_wdata(req_wdata),
    .req_signed(req_signed), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .err(err), .load_valid(load_valid), .load_data(load_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: sizes in bytes, alignment by modulo arithmetic.
  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  task automatic do_req(input logic [AW-1:0] a, input logic [1:0] sz, input logic st,
                        input logic [31:0] wd, input logic sg);
    int n;
    bit ok;
    int base;
    logic [3:0]  exp_be;
    logic [31:0] exp_wd, exp_ld;
    n  = nbytes(sz);
    ok = (n != 0) && ((a % n) == 0);
    base = a - (a % 4);
    exp_be = 4'b0000;
    if (ok && st) for (int k = 0; k < n; k++) exp_be[(a % 4) + k] = 1'b1;
    exp_wd = (n == 1) ? {wd[7:0], wd[7:0], wd[7:0], wd[7:0]} :
             (n == 2) ? {wd[15:0], wd[15:0]} : wd;
    exp_ld = 0;
    if (ok && !st) begin
      for (int k = 0; k < n; k++) exp_ld = exp_ld | (32'(model[a + k]) << (8 * k));
      if (sg && n < 4 && exp_ld[8*n-1]) exp_ld = exp_ld | (32'hFFFF_FFFF << (8 * n));
    end
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_store = st; req_wdata = wd; req_signed = sg;
    #2;
    check(n == 4 ? "R2" : n == 2 ? "R3" : n == 1 ? "R4" : "R6", {28'd0, mem_be}, {28'd0, exp_be});
    if (ok && st) check("R5", mem_wdata, exp_wd);
    if (ok && st) for (int k = 0; k < n; k++) model[a + k] = wd[8*k +: 8];
    @(posedge clk);
    #2;
    req_valid = 0;
    check("R6", {31'd0, err}, {31'd0, !ok});
    check("R9", {31'd0, load_valid}, {31'd0, ok && !st});
    if (!(ok && !st)) check("R9", load_data, 32'd0);
    else if (sg) check("R8", load_data, exp_ld);
    else check("R7", load_data, exp_ld);
    if (base < 0) check("R1", 0, 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {31'd0, err}, 0);
    check("R11", {31'd0, load_valid}, 0);
    check("R11", load_data, 0);
    rst_n = 1;
    // Fill all words with a known pattern
    for (int w = 0; w < NBYTES / 4; w++) do_req(AW'(w * 4), 2'b10, 1, 32'h8A5C_3E71 ^ (w * 32'h0101_0101), 0);
    // R2/R7 word store and load back
    do_req(8'h10, 2'b10, 1, 32'hF1E2_D3C4, 0);
    do_req(8'h10, 2'b10, 0, 0, 0);
    // R3/R10 halfword stores at both halves, neighbours kept
    do_req(8'h20, 2'b10, 1, 32'h1122_3344, 0);
    do_req(8'h22, 2'b01, 1, 32'h0000_8001, 0);
    do_req(8'h20, 2'b10, 0, 0, 0);
    do_req(8'h20, 2'b01, 1, 32'hABCD_7FFE, 0);
    do_req(8'h20, 2'b10, 0, 0, 0);
    // R4/R10 bytes in each lane, R7/R8 extension boundaries
    for (int l = 0; l < 4; l++) do_req(AW'(8'h30 + l), 2'b00, 1, 32'h80 + l * 32'h3F, 0);
    do_req(8'h30, 2'b10, 0, 0, 0);
    for (int l = 0; l < 4; l++) begin
      do_req(AW'(8'h30 + l), 2'b00, 0, 0, 0);
      do_req(AW'(8'h30 + l), 2'b00, 0, 0, 1);
    end
    do_req(8'h22, 2'b01, 0, 0, 1);
    do_req(8'h22, 2'b01, 0, 0, 0);
    // R1/R6 misaligned and reserved, memory must stay unchanged
    do_req(8'h41, 2'b01, 1, 32'hDEAD_BEEF, 0);
    do_req(8'h42, 2'b10, 1, 32'hDEAD_BEEF, 0);
    do_req(8'h40, 2'b11, 1, 32'hDEAD_BEEF, 0);
    do_req(8'h43, 2'b01, 0, 0, 1);
    do_req(8'h40, 2'b11, 0, 0, 0);
    do_req(8'h40, 2'b10, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 4000; i++)
      do_req(AW'($urandom), 2'($urandom), 1'($urandom), $urandom, 1'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule